// File: doc/BRIEF.md
# Priority Throttle Arbiter with Fractional Clock-Pulse Skippers

This block holds a small set of throttle events. Each event has a stored configuration made of a priority, a CPU skip depth given as a percentage, and a two-bit GPU skip level. Each cycle the block looks at the request lines. Among the events that are both requested and enabled, it picks the one with the largest priority and presents that event's settings on its outputs. A higher priority is meant to carry a deeper skip, so the winner gives the lowest clock rate. Each request is a plain on/off cooling demand and has no intermediate states.

The chosen settings drive two clock-enable pulse skippers, one for the CPU clock domain and one for the GPU clock domain. Each skipper runs a 100-step period with an accumulator. In every period it drops exactly the configured share of enable pulses and spreads the drops evenly. A new depth is loaded only when a period ends, so the drop pattern never changes part way through a period. Software sets each event's configuration through a single-cycle write port that writes the whole record in one cycle.

Top module: `heat_throttle_arbiter`

## Requirements
- R1: A cycle with `cfg_we` high stores `cfg_prio`, `cfg_cpu_pct` and `cfg_gpu_lvl` into the event selected by `cfg_sel`. The new record takes part in selection from the next clock edge onward. After reset every event has priority 0.
- R2: Among events whose `evt_req` bit is high and whose priority is enabled, the one with the largest priority wins. `sel_valid`, `sel_idx`, `sel_cpu_pct` and `sel_gpu_pct` are registered and reflect the requests and configuration of the previous clock edge.
- R3: When several requested, enabled events share the largest priority, the lowest event index wins.
- R4: An event whose priority is 0, or greater than 100, is disabled and is never selected, even when it is requested.
- R5: The GPU level code maps to a skip percentage as follows: 0 gives 0, 1 gives 50, 2 gives 75 and 3 gives 85. That percentage appears on `sel_gpu_pct`.
- R6: The CPU depth is used directly as a percentage of pulses to remove. A written value above 100 is stored as 100.
- R7: After reset, and whenever no enabled event is requested, `sel_valid`, `sel_idx`, `sel_cpu_pct` and `sel_gpu_pct` are all 0. Once a period with depth 0 is running, both clock enables stay high.
- R8: While a skipper's depth N stays fixed, its enable is low in exactly N cycles of any 100 consecutive cycles.
- R9: Removed pulses are spread evenly. At depths up to 50 no two removed pulses are adjacent. At depth 100 every pulse is removed.
- R10: The 100-cycle period starts when reset is released. A new depth is loaded only at the wrap from the last period cycle to the first, so a request raised mid-period leaves the rest of that period unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | IDX_W | Event index being written |
| cfg_prio | input | PRIO_W | Priority to store (1..100 enabled) |
| cfg_cpu_pct | input | 7 | CPU skip percentage to store |
| cfg_gpu_lvl | input | 2 | GPU skip level code to store |
| evt_req | input | N_EVT | One on/off request per event |
| sel_valid | output | 1 | An enabled event is requested |
| sel_idx | output | IDX_W | Index of the winning event |
| sel_cpu_pct | output | 7 | Winning CPU skip percentage |
| sel_gpu_pct | output | 7 | Winning GPU skip percentage |
| cpu_clk_en | output | 1 | CPU clock enable after skipping |
| gpu_clk_en | output | 1 | GPU clock enable after skipping |

## Verification
A configuration write lands at one edge, and the selection outputs follow the request at the next edge. The bench therefore drives every input just after a falling edge and reads the `sel_*` outputs at the following falling edge, one full cycle later. The skipper outputs lag the selection by up to one whole period. Skip counts are taken only after the bench has waited 200 cycles for the new depth to settle, and then over exactly 100 consecutive samples. For the period-boundary check, the bench counts cycles from reset release to track the period phase. It raises a request at phase 30, expects the enable to stay high through phase 99, and expects the enable to drop at phase 0.

// File: rtl/thr_pkg.sv
package thr_pkg;
   // Percent scale shared by the selection outputs and the skippers.
   localparam int PCT_FULL = 100;
   localparam int PCT_W    = 7;
   localparam int LVL_W    = 2;

   typedef logic [PCT_W-1:0] pct_t;

   typedef enum logic [LVL_W-1:0] {
      LVL_OFF  = 2'd0,
      LVL_LITE = 2'd1,
      LVL_MID  = 2'd2,
      LVL_DEEP = 2'd3
   } skip_lvl_e;
endpackage

// File: rtl/thr_cfg_bank.sv
module thr_cfg_bank
   import thr_pkg::*;
#(
   parameter int N_EVT  = 4,
   parameter int PRIO_W = 7,
   localparam int IDX_W = $clog2(N_EVT)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_sel,
   input  logic [PRIO_W-1:0]             wr_prio,
   input  logic [PCT_W-1:0]              wr_cpu,
   input  logic [LVL_W-1:0]              wr_lvl,
   output logic [N_EVT-1:0][PRIO_W-1:0]  prio_o,
   output logic [N_EVT-1:0][PCT_W-1:0]   cpu_o,
   output logic [N_EVT-1:0][LVL_W-1:0]   lvl_o
);
   // Clamp the CPU depth once, at write time.
   pct_t cpu_lim;
   always_comb begin
      cpu_lim = (wr_cpu > PCT_W'(PCT_FULL)) ? PCT_W'(PCT_FULL) : wr_cpu;
   end

   for (genvar g = 0; g < N_EVT; g++) begin : g_slot
      logic hit;
      assign hit = wr_en && (wr_sel == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prio_o[g] <= '0;
            cpu_o[g]  <= '0;
            lvl_o[g]  <= '0;
         end else if (hit) begin
            prio_o[g] <= wr_prio;
            cpu_o[g]  <= cpu_lim;
            lvl_o[g]  <= wr_lvl;
         end
      end
   end
endmodule

// File: rtl/thr_pick.sv
module thr_pick
   import thr_pkg::*;
#(
   parameter int N_EVT    = 4,
   parameter int PRIO_W   = 7,
   parameter int PRIO_MAX = 100,
   parameter int LOW_PCT  = 50,
   parameter int MED_PCT  = 75,
   parameter int HIGH_PCT = 85,
   localparam int IDX_W   = $clog2(N_EVT)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_EVT-1:0]              req_i,
   input  logic [N_EVT-1:0][PRIO_W-1:0]  prio_i,
   input  logic [N_EVT-1:0][PCT_W-1:0]   cpu_i,
   input  logic [N_EVT-1:0][LVL_W-1:0]   lvl_i,
   output logic                          valid_o,
   output logic [IDX_W-1:0]              idx_o,
   output logic [PCT_W-1:0]              cpu_o,
   output logic [PCT_W-1:0]              gpu_o
);
   function automatic pct_t lvl_to_pct(input logic [LVL_W-1:0] code);
      pct_t r;
      case (skip_lvl_e'(code))
         LVL_LITE: r = PCT_W'(LOW_PCT);
         LVL_MID:  r = PCT_W'(MED_PCT);
         LVL_DEEP: r = PCT_W'(HIGH_PCT);
         default:  r = '0;
      endcase
      return r;
   endfunction

   // An event is eligible when it is requested and its priority is in range.
   logic [N_EVT-1:0] elig;
   for (genvar g = 0; g < N_EVT; g++) begin : g_elig
      assign elig[g] = req_i[g] && (prio_i[g] != '0) &&
                       (prio_i[g] <= PRIO_W'(PRIO_MAX));
   end

   // Linear scan with a strict compare: on a tie, the earlier index is kept.
   logic              found;
   logic [PRIO_W-1:0] best_p;
   logic [IDX_W-1:0]  best_i;
   always_comb begin
      found  = 1'b0;
      best_p = '0;
      best_i = '0;
      for (int i = 0; i < N_EVT; i++) begin
         if (elig[i] && (!found || (prio_i[i] > best_p))) begin
            found  = 1'b1;
            best_p = prio_i[i];
            best_i = IDX_W'(i);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         idx_o   <= '0;
         cpu_o   <= '0;
         gpu_o   <= '0;
      end else begin
         valid_o <= found;
         idx_o   <= found ? best_i : '0;
         cpu_o   <= found ? cpu_i[best_i] : '0;
         gpu_o   <= found ? lvl_to_pct(lvl_i[best_i]) : '0;
      end
   end
endmodule

// File: rtl/thr_skipper.sv
module thr_skipper #(
   parameter int STEPS = 100,
   parameter int DW    = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] depth_i,
   output logic          pass_o
);
   localparam int PH_W = $clog2(STEPS);
   localparam int AW   = $clog2(2 * STEPS + 1);

   if (STEPS < 2) begin : g_bad_steps
      $error("thr_skipper: STEPS must be at least 2");
   end

   logic [PH_W-1:0] phase_q;
   logic [AW-1:0]   acc_q;
   logic [AW-1:0]   dep_q;
   logic [AW-1:0]   dep_lim;
   logic [AW-1:0]   sum;
   logic            drop;
   logic            wrap;

   always_comb begin
      dep_lim = (AW'(depth_i) > AW'(STEPS)) ? AW'(STEPS) : AW'(depth_i);
      sum     = acc_q + dep_q;
      drop    = (sum >= AW'(STEPS));
      wrap    = (phase_q == PH_W'(STEPS - 1));
      pass_o  = !drop;
   end

   // The depth and accumulator restart together at the period wrap, so each
   // period removes exactly dep_q pulses.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
         acc_q   <= '0;
         dep_q   <= '0;
      end else if (wrap) begin
         phase_q <= '0;
         acc_q   <= '0;
         dep_q   <= dep_lim;
      end else begin
         phase_q <= phase_q + PH_W'(1);
         acc_q   <= drop ? (sum - AW'(STEPS)) : sum;
      end
   end
endmodule

// File: rtl/heat_throttle_arbiter.sv
module heat_throttle_arbiter
   import thr_pkg::*;
#(
   parameter int N_EVT    = 4,
   parameter int PRIO_W   = 7,
   parameter int PRIO_MAX = 100,
   parameter int LOW_PCT  = 50,
   parameter int MED_PCT  = 75,
   parameter int HIGH_PCT = 85,
   localparam int IDX_W   = $clog2(N_EVT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [IDX_W-1:0]   cfg_sel,
   input  logic [PRIO_W-1:0]  cfg_prio,
   input  logic [6:0]         cfg_cpu_pct,
   input  logic [1:0]         cfg_gpu_lvl,
   input  logic [N_EVT-1:0]   evt_req,
   output logic               sel_valid,
   output logic [IDX_W-1:0]   sel_idx,
   output logic [6:0]         sel_cpu_pct,
   output logic [6:0]         sel_gpu_pct,
   output logic               cpu_clk_en,
   output logic               gpu_clk_en
);
   if (N_EVT < 2) begin : g_bad_n
      $error("heat_throttle_arbiter: N_EVT must be at least 2");
   end
   if (PRIO_MAX < 1 || PRIO_MAX >= (1 << PRIO_W)) begin : g_bad_prio
      $error("heat_throttle_arbiter: PRIO_MAX must fit in PRIO_W bits");
   end
   if (LOW_PCT > PCT_FULL || MED_PCT > PCT_FULL || HIGH_PCT > PCT_FULL) begin : g_bad_lvl
      $error("heat_throttle_arbiter: level percentages exceed full scale");
   end

   logic [N_EVT-1:0][PRIO_W-1:0] prio_w;
   logic [N_EVT-1:0][PCT_W-1:0]  cpu_w;
   logic [N_EVT-1:0][LVL_W-1:0]  lvl_w;

   thr_cfg_bank #(.N_EVT(N_EVT), .PRIO_W(PRIO_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_we),
      .wr_sel (cfg_sel),
      .wr_prio(cfg_prio),
      .wr_cpu (cfg_cpu_pct),
      .wr_lvl (cfg_gpu_lvl),
      .prio_o (prio_w),
      .cpu_o  (cpu_w),
      .lvl_o  (lvl_w)
   );

   thr_pick #(
      .N_EVT(N_EVT), .PRIO_W(PRIO_W), .PRIO_MAX(PRIO_MAX),
      .LOW_PCT(LOW_PCT), .MED_PCT(MED_PCT), .HIGH_PCT(HIGH_PCT)
   ) u_pick (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (evt_req),
      .prio_i (prio_w),
      .cpu_i  (cpu_w),
      .lvl_i  (lvl_w),
      .valid_o(sel_valid),
      .idx_o  (sel_idx),
      .cpu_o  (sel_cpu_pct),
      .gpu_o  (sel_gpu_pct)
   );

   // One skipper per clock domain; index 0 is CPU, index 1 is GPU.
   logic [1:0][PCT_W-1:0] dom_depth;
   logic [1:0]            dom_pass;
   assign dom_depth[0] = sel_cpu_pct;
   assign dom_depth[1] = sel_gpu_pct;

   for (genvar d = 0; d < 2; d++) begin : g_dom
      thr_skipper #(.STEPS(PCT_FULL), .DW(PCT_W)) u_skip (
         .clk    (clk),
         .rst_n  (rst_n),
         .depth_i(dom_depth[d]),
         .pass_o (dom_pass[d])
      );
   end

   assign cpu_clk_en = dom_pass[0];
   assign gpu_clk_en = dom_pass[1];
endmodule

// File: rtl/thr_arb_chk.sv
module thr_arb_chk #(
   parameter int N_EVT    = 4,
   parameter int IDX_W    = 2,
   parameter int LOW_PCT  = 50,
   parameter int MED_PCT  = 75,
   parameter int HIGH_PCT = 85
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_EVT-1:0] evt_req,
   input logic             sel_valid,
   input logic [IDX_W-1:0] sel_idx,
   input logic [6:0]       sel_cpu_pct,
   input logic [6:0]       sel_gpu_pct
);
   logic             seen_q;
   logic [N_EVT-1:0] req_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         req_q  <= '0;
      end else begin
         seen_q <= 1'b1;
         req_q  <= evt_req;
      end
   end

   // R2: the winner was requested at the previous edge
   p_winner_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && sel_valid) |-> req_q[sel_idx]);

   // R5: GPU percentage is one of the four level values
   p_gpu_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_gpu_pct == 7'd0) || (sel_gpu_pct == 7'(LOW_PCT)) ||
      (sel_gpu_pct == 7'(MED_PCT)) || (sel_gpu_pct == 7'(HIGH_PCT)));

   // R6: CPU percentage never exceeds full scale
   p_cpu_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sel_cpu_pct <= 7'd100);

   // R7: no selection means zero settings
   p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_valid |-> (sel_idx == '0 && sel_cpu_pct == 7'd0 && sel_gpu_pct == 7'd0));

   // R7: nothing requested at the previous edge means no selection
   p_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && req_q == '0) |-> !sel_valid);
endmodule

bind heat_throttle_arbiter thr_arb_chk #(
   .N_EVT(N_EVT), .IDX_W(IDX_W),
   .LOW_PCT(LOW_PCT), .MED_PCT(MED_PCT), .HIGH_PCT(HIGH_PCT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .evt_req    (evt_req),
   .sel_valid  (sel_valid),
   .sel_idx    (sel_idx),
   .sel_cpu_pct(sel_cpu_pct),
   .sel_gpu_pct(sel_gpu_pct)
);

// File: tb/sim_heat_throttle_arbiter.sv
module sim_heat_throttle_arbiter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_sel = '0;
   logic [6:0] cfg_prio = '0;
   logic [6:0] cfg_cpu_pct = '0;
   logic [1:0] cfg_gpu_lvl = '0;
   logic [3:0] evt_req = '0;
   logic       sel_valid;
   logic [1:0] sel_idx;
   logic [6:0] sel_cpu_pct;
   logic [6:0] sel_gpu_pct;
   logic       cpu_clk_en;
   logic       gpu_clk_en;

   int n_chk = 0;
   int n_fail = 0;
   int unsigned cyc = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   heat_throttle_arbiter u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_prio(cfg_prio), .cfg_cpu_pct(cfg_cpu_pct), .cfg_gpu_lvl(cfg_gpu_lvl),
      .evt_req(evt_req), .sel_valid(sel_valid), .sel_idx(sel_idx),
      .sel_cpu_pct(sel_cpu_pct), .sel_gpu_pct(sel_gpu_pct),
      .cpu_clk_en(cpu_clk_en), .gpu_clk_en(gpu_clk_en)
   );

   typedef struct packed {
      logic [3:0] req;
      logic       v;
      logic [1:0] idx;
      logic [6:0] cpu;
      logic [6:0] gpu;
   } vec_t;

   // Config: ev0 (80,50,lvl1) ev1 (100,85,lvl3) ev2 (50,75,lvl2) ev3 (80,30,lvl0)
   localparam vec_t VEC [10] = '{
      '{4'b0001, 1'b1, 2'd0, 7'd50, 7'd50},
      '{4'b0010, 1'b1, 2'd1, 7'd85, 7'd85},
      '{4'b0011, 1'b1, 2'd1, 7'd85, 7'd85},
      '{4'b0101, 1'b1, 2'd0, 7'd50, 7'd50},
      '{4'b1001, 1'b1, 2'd0, 7'd50, 7'd50},
      '{4'b1000, 1'b1, 2'd3, 7'd30, 7'd0},
      '{4'b0100, 1'b1, 2'd2, 7'd75, 7'd75},
      '{4'b0000, 1'b0, 2'd0, 7'd0,  7'd0},
      '{4'b1100, 1'b1, 2'd3, 7'd30, 7'd0},
      '{4'b1111, 1'b1, 2'd1, 7'd85, 7'd85}
   };

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input int idx, input int prio, input int cpu, input int lvl);
      cfg_we = 1'b1; cfg_sel = 2'(idx); cfg_prio = 7'(prio);
      cfg_cpu_pct = 7'(cpu); cfg_gpu_lvl = 2'(lvl);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic apply(input logic [3:0] r);
      evt_req = r;
      @(negedge clk);
   endtask

   task automatic window(output int c_sk, output int g_sk, output int adj);
      bit prev = 1'b0;
      c_sk = 0; g_sk = 0; adj = 0;
      for (int k = 0; k < 100; k++) begin
         @(negedge clk);
         if (!cpu_clk_en) c_sk++;
         if (!gpu_clk_en) g_sk++;
         if (!cpu_clk_en && prev) adj++;
         prev = !cpu_clk_en;
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL R10 watchdog actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

   initial begin
      int cs, gs, ad, viol;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R7: reset state
      check("R7 reset valid", sel_valid, 0);
      check("R7 reset cpu_en", cpu_clk_en, 1);
      check("R7 reset gpu_en", gpu_clk_en, 1);

      // R1: configure the four events
      wr(0, 80, 50, 1);
      wr(1, 100, 85, 3);
      wr(2, 50, 75, 2);
      wr(3, 80, 30, 0);

      // R2, R3, R5: vector table
      for (int i = 0; i < 10; i++) begin
         apply(VEC[i].req);
         check("R2 valid", sel_valid, VEC[i].v);
         check("R3 idx", sel_idx, VEC[i].idx);
         check("R6 cpu", sel_cpu_pct, VEC[i].cpu);
         check("R5 gpu", sel_gpu_pct, VEC[i].gpu);
      end

      // R8, R9: steady skip counts
      apply(4'b0001);
      repeat (200) @(negedge clk);
      window(cs, gs, ad);
      check("R8 cpu 50", cs, 50);
      check("R8 gpu 50", gs, 50);
      check("R9 no adjacent at 50", ad, 0);
      apply(4'b0010);
      repeat (200) @(negedge clk);
      window(cs, gs, ad);
      check("R8 cpu 85", cs, 85);
      check("R8 gpu 85", gs, 85);
      apply(4'b1000);
      repeat (200) @(negedge clk);
      window(cs, gs, ad);
      check("R8 cpu 30", cs, 30);
      check("R5 gpu lvl0", gs, 0);
      check("R9 no adjacent at 30", ad, 0);

      // R4: disabled priorities
      wr(1, 0, 85, 3);
      apply(4'b0010);
      check("R4 prio0 valid", sel_valid, 0);
      wr(1, 101, 85, 3);
      apply(4'b0010);
      check("R4 prio101 valid", sel_valid, 0);
      apply(4'b0011);
      check("R4 fallback idx", sel_idx, 0);

      // R6, R1: clamp on write
      wr(2, 60, 120, 0);
      apply(4'b0100);
      check("R6 clamp idx", sel_idx, 2);
      check("R6 clamp cpu", sel_cpu_pct, 100);
      check("R1 new gpu", sel_gpu_pct, 0);

      // R7: idle passes every pulse
      apply(4'b0000);
      repeat (200) @(negedge clk);
      window(cs, gs, ad);
      check("R7 idle cpu skips", cs, 0);
      check("R7 idle gpu skips", gs, 0);

      // R10: request raised mid-period takes effect at the wrap
      while ((cyc % 100) != 30) @(negedge clk);
      evt_req = 4'b0100;
      viol = 0;
      while ((cyc % 100) != 0) begin
         @(negedge clk);
         if ((cyc % 100) != 0 && !cpu_clk_en) viol++;
      end
      check("R10 no early drop", viol, 0);
      check("R10 drop at wrap", cpu_clk_en, 0);

      // R9: full depth removes all pulses
      window(cs, gs, ad);
      check("R9 full cpu", cs, 100);
      check("R9 full gpu lvl0", gs, 0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule